// File: doc/BRIEF.md
# Dual-Channel Serial Step-Attenuator Controller

This block sets two 6-bit step attenuators. Each attenuator is driven through its own three-wire serial port: a serial clock, a data line and a latch strobe. A host offers one request at a time on a valid/ready handshake. A request holds a channel number and an attenuation in half-dB steps. The block turns the request into a 6-bit control word. The word equals the number of half-dB steps, so 0 means the least attenuation and all ones means 31.5 dB. A request above 63 steps is clipped to all ones.

The block then shifts the word into the selected port, most significant bit first. The target samples each bit on a rising serial clock edge. Once all six bits are in, the block pulses the latch strobe once, and only that pulse applies the new setting. All timing is counted in system-clock cycles. The serial clock high and low phases are equal, and each lasts `PHASE`, the largest of the half-period, setup and hold parameters. With the default values at a 100 MHz system clock, this gives a 25 MHz serial clock, 20 ns of setup and 20 ns of hold. During a transfer, `busy` is high. A one-cycle `done` pulse follows once the strobe has returned low.

Top module: `dual_atten_ctrl`

## Requirements
- R1: An accepted request of N half-dB steps with N <= 63 ends with the selected target holding the 6-bit code N. The bits are sent on `ser_data`, most significant bit first, one bit per rising edge of `ser_clk`.
- R2: An accepted request above 63 loads code 111111. In this case `out_of_range` is high for exactly the one cycle after acceptance. `out_of_range` stays low for every request of 63 or less.
- R3: `ser_data` of the active channel is stable for at least `SETUP_CYC` cycles before each rising edge of `ser_clk`.
- R4: `ser_data` does not change within `HOLD_CYC` cycles after a rising edge of `ser_clk`.
- R5: Within a transfer, each high phase of `ser_clk` lasts exactly PHASE = max(`HALF_CYC`, `SETUP_CYC`, `HOLD_CYC`) cycles. Each low phase between two bits also lasts exactly PHASE cycles. `ser_clk` idles low.
- R6: A transfer has exactly six rising edges of `ser_clk`, followed by one `ser_le` pulse. The pulse rises with `ser_clk` low, at least `HOLD_CYC` cycles after the last rising edge, and stays high for at least PHASE cycles.
- R7: `busy` is high in the cycle after acceptance. `done` is a single-cycle pulse that comes with every `ser_le` line already low.
- R8: `req_ready` is high only while idle. A request offered while busy is ignored: it produces no line activity and no later transfer once `req_valid` is dropped.
- R9: The clock, data and latch lines of the channel that is not selected do not change during a transfer.
- R10: After reset, `ser_clk`, `ser_data`, `ser_le`, `busy`, `done` and `out_of_range` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_chan | input | CH_W | Channel to program |
| req_half_db | input | REQ_W | Attenuation in 0.5 dB steps |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| out_of_range | output | 1 | One-cycle pulse: request was clipped |
| ser_clk | output | NCH | Serial clock, one per channel |
| ser_data | output | NCH | Serial data, one per channel |
| ser_le | output | NCH | Latch strobe, one per channel |

## Verification
The bench builds the block with `SETUP_CYC`=1, `HOLD_CYC`=2 and `HALF_CYC`=1. With these values PHASE comes from the hold parameter and not the half-period, which tests the max rule, while a transfer stays short. That makes it practical to sweep every request from 0 to 70, plus 128 and 255, alternating between the channels. Each transfer is checked by a target model. The model measures setup, hold and phase lengths, captures the shifted word on the strobe, and watches the idle channel while a competing request is held during the busy time.

// File: rtl/atten_pkg.sv
package atten_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LATCH,
    ST_DONE
  } seq_state_t;

  // Clip a half-dB request to the largest code.
  function automatic int unsigned sat_code(int unsigned req, int unsigned max_code);
    return (req > max_code) ? max_code : req;
  endfunction

  // Common phase length that satisfies half-period, setup and hold.
  function automatic int unsigned phase_len(int unsigned half, int unsigned su, int unsigned hd);
    int unsigned m;
    m = half;
    if (su > m) m = su;
    if (hd > m) m = hd;
    if (m == 0) m = 1;
    return m;
  endfunction

endpackage

// File: rtl/atten_seq.sv
module atten_seq
  import atten_pkg::*;
#(
  parameter int WORD  = 6,
  parameter int REQ_W = 8,
  parameter int NCH   = 2,
  parameter int CH_W  = 1,
  parameter int PHASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [REQ_W-1:0] req_half_db,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic             oor,
  output logic [NCH-1:0]   sel,
  output logic             want_clk,
  output logic             want_data,
  output logic             load_data,
  output logic             want_le
);

  localparam int IDX_W    = (WORD > 1) ? $clog2(WORD) : 1;
  localparam int CNT_W    = $clog2(PHASE + 1);
  localparam int MAX_CODE = (1 << WORD) - 1;

  seq_state_t       state;
  logic [WORD-1:0]  word_q;
  logic [CH_W-1:0]  chan_q;
  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] cnt;
  logic             done_q;
  logic             oor_q;

  // Named internal events
  wire accept   = req_valid && (state == ST_IDLE);
  wire cnt_last = (cnt == CNT_W'(PHASE - 1));
  wire last_bit = (bit_idx == '0);
  wire req_big  = (32'(req_half_db) > MAX_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      word_q  <= '0;
      chan_q  <= '0;
      bit_idx <= '0;
      cnt     <= '0;
      done_q  <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      done_q <= (state == ST_DONE);
      oor_q  <= accept && req_big;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            word_q  <= WORD'(sat_code(32'(req_half_db), MAX_CODE));
            chan_q  <= req_chan;
            bit_idx <= IDX_W'(WORD - 1);
            cnt     <= '0;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (cnt_last) begin
            cnt   <= '0;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_last) begin
            cnt <= '0;
            if (last_bit) begin
              state <= ST_LATCH;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              state   <= ST_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LATCH: begin
          if (cnt_last) begin
            cnt   <= '0;
            state <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (state != ST_IDLE) && (32'(chan_q) == i);
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign oor       = oor_q;
  assign want_clk  = (state == ST_HIGH);
  assign want_le   = (state == ST_LATCH);
  assign load_data = (state == ST_LOW) && (cnt == '0);
  assign want_data = word_q[bit_idx];

  // R5: phase counter never runs past one phase
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(PHASE));

  // R7: done pulse only once the sequencer is back to idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));

  // R2: the clip flag comes with a saturated word
  a_r2_oor_sat: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (word_q == WORD'(MAX_CODE)));

  // R2: the flag lasts one cycle
  a_r2_oor_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    oor |=> !oor);

  // R6: latch phase entered only after the last bit
  a_r6_latch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH) |-> last_bit);

endmodule

// File: rtl/atten_port.sv
module atten_port (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic want_clk,
  input  logic want_data,
  input  logic load_data,
  input  logic want_le,
  output logic sclk,
  output logic sdata,
  output logic le
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      sdata <= 1'b0;
      le    <= 1'b0;
    end else if (sel) begin
      sclk <= want_clk;
      le   <= want_le;
      if (load_data) sdata <= want_data;
    end
  end

  // R6: strobe only while the serial clock is low
  a_r6_le_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk);

  // R4: data never moves while the clock is high
  a_r4_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

endmodule

// File: rtl/dual_atten_ctrl.sv
module dual_atten_ctrl
  import atten_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int WORD      = 6,
  parameter int REQ_W     = 8,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int HALF_CYC  = 2,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [REQ_W-1:0] req_half_db,
  output logic             busy,
  output logic             done,
  output logic             out_of_range,
  output logic [NCH-1:0]   ser_clk,
  output logic [NCH-1:0]   ser_data,
  output logic [NCH-1:0]   ser_le
);

  localparam int PHASE = phase_len(HALF_CYC, SETUP_CYC, HOLD_CYC);

  logic [NCH-1:0] sel;
  logic           want_clk;
  logic           want_data;
  logic           load_data;
  logic           want_le;

  atten_seq #(
    .WORD (WORD),
    .REQ_W(REQ_W),
    .NCH  (NCH),
    .CH_W (CH_W),
    .PHASE(PHASE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .req_half_db(req_half_db),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .oor        (out_of_range),
    .sel        (sel),
    .want_clk   (want_clk),
    .want_data  (want_data),
    .load_data  (load_data),
    .want_le    (want_le)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_port
    atten_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel[g]),
      .want_clk (want_clk),
      .want_data(want_data),
      .load_data(load_data),
      .want_le  (want_le),
      .sclk     (ser_clk[g]),
      .sdata    (ser_data[g]),
      .le       (ser_le[g])
    );
  end

  // R9: at most one port is clocking or strobing at any time
  a_r9_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_clk | ser_le));

  // R7: done arrives with every strobe low
  a_r7_done_le_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ser_le == '0));

  // R8: no acceptance while a transfer runs
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

endmodule

// File: tb/dual_atten_ctrl_test.sv
`timescale 1ns/1ps
module dual_atten_ctrl_test;

  localparam int SU    = 1;
  localparam int HD    = 2;
  localparam int HALF  = 1;
  localparam int PH    = (HALF > SU) ? ((HALF > HD) ? HALF : HD) : ((SU > HD) ? SU : HD);
  localparam int BITS  = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [0:0] req_chan = '0;
  logic [7:0] req_half_db = '0;
  logic       busy, done, out_of_range;
  logic [1:0] ser_clk, ser_data, ser_le;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dual_atten_ctrl #(
    .NCH(2), .WORD(6), .REQ_W(8),
    .SETUP_CYC(SU), .HOLD_CYC(HD), .HALF_CYC(HALF)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_half_db(req_half_db),
    .busy(busy), .done(done), .out_of_range(out_of_range),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Serial target model, one per channel
  int pc[2], pd[2], pl[2];
  int stab[2], since_rise[2], hrun[2], lrun[2], lerun[2];
  int nbits[2], shreg[2], latched[2], pulses[2], act[2];

  initial begin
    for (int c = 0; c < 2; c++) begin
      pc[c] = 0; pd[c] = 0; pl[c] = 0; stab[c] = 0; since_rise[c] = 1000;
      hrun[c] = 0; lrun[c] = 0; lerun[c] = 0; nbits[c] = 0; shreg[c] = 0;
      latched[c] = -1; pulses[c] = 0; act[c] = 0;
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      int ck, dt, lt;
      ck = int'(ser_clk[c]); dt = int'(ser_data[c]); lt = int'(ser_le[c]);
      if (ck != pc[c] || dt != pd[c] || lt != pl[c]) act[c]++;
      if (since_rise[c] < 1000) since_rise[c]++;
      if (dt != pd[c]) begin
        check(since_rise[c] >= HD, "R4 hold after rising edge", since_rise[c], HD);
        stab[c] = 0;
      end else begin
        stab[c]++;
      end
      if (ck == 1 && pc[c] == 0) begin
        check(stab[c] >= SU, "R3 setup before rising edge", stab[c], SU);
        if (nbits[c] > 0) check(lrun[c] == PH, "R5 low phase length", lrun[c], PH);
        shreg[c] = ((shreg[c] << 1) | dt) & 63;
        nbits[c]++;
        since_rise[c] = 0;
        hrun[c] = 0;
      end
      if (ck == 0 && pc[c] == 1) begin
        check(hrun[c] == PH, "R5 high phase length", hrun[c], PH);
        lrun[c] = 0;
      end
      if (ck == 1) hrun[c]++; else lrun[c]++;
      if (lt == 1 && pl[c] == 0) begin
        check(nbits[c] == BITS, "R6 bit count before strobe", nbits[c], BITS);
        check(since_rise[c] >= HD, "R6 strobe after last hold", since_rise[c], HD);
        check(ck == 0, "R6 strobe with clock low", ck, 0);
        latched[c] = shreg[c];
        pulses[c]++;
        lerun[c] = 0;
      end
      if (lt == 0 && pl[c] == 1) begin
        check(lerun[c] >= PH, "R6 strobe width", lerun[c], PH);
        nbits[c] = 0;
      end
      if (lt == 1) lerun[c]++;
      pc[c] = ck; pd[c] = dt; pl[c] = lt;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_xfer(input int ch, input int v);
    int oth, act_o, lat_o, pul_c, pul_o, exp, n;
    oth = 1 - ch;
    step();
    while (!req_ready) step();
    act_o = act[oth]; lat_o = latched[oth]; pul_c = pulses[ch]; pul_o = pulses[oth];
    exp = (v > 63) ? 63 : v;
    req_valid = 1'b1; req_chan = 1'(ch); req_half_db = 8'(v);
    step();
    check(int'(out_of_range) == ((v > 63) ? 1 : 0), "R2 clip flag", int'(out_of_range), (v > 63) ? 1 : 0);
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    check(req_ready == 1'b0, "R8 not ready while busy", int'(req_ready), 0);
    req_chan = 1'(oth); req_half_db = 8'(5);
    step();
    check(out_of_range == 1'b0, "R2 clip flag one cycle", int'(out_of_range), 0);
    for (int k = 0; k < 3; k++) step();
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin step(); n++; end
    check(done == 1'b1, "R7 done reached", int'(done), 1);
    check(ser_le == 2'b00, "R7 strobe low at done", int'(ser_le), 0);
    check(latched[ch] == exp, (v > 63) ? "R2 saturated code" : "R1 latched code", latched[ch], exp);
    check(pulses[ch] == pul_c + 1, "R6 one strobe", pulses[ch], pul_c + 1);
    check(act[oth] == act_o, "R9 idle channel lines", act[oth], act_o);
    check(latched[oth] == lat_o && pulses[oth] == pul_o, "R8 ignored request", latched[oth], lat_o);
    step();
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    check(busy == 1'b0, "R8 no transfer from ignored request", int'(busy), 0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check(ser_clk == 2'b00 && ser_le == 2'b00 && ser_data == 2'b00, "R10 lines low in reset",
          int'({ser_clk, ser_data, ser_le}), 0);
    rst_n = 1'b1;
    step();
    check(busy == 1'b0 && done == 1'b0 && out_of_range == 1'b0, "R10 status after reset",
          int'({busy, done, out_of_range}), 0);
    check(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    for (int v = 0; v <= 70; v++) do_xfer(v % 2, v);
    do_xfer(0, 128);
    do_xfer(1, 255);
    do_xfer(1, 0);
    do_xfer(0, 42);
    finished = 1;
    report();
    $finish;
  end

endmodule